// File: doc/BRIEF.md
# Two-Step ADC Bus Interface Sequencer

This block is the device-side control logic of an 8-bit two-step converter that sits on a parallel processor bus. It watches active-low chip select, read and write strobes, runs an upper-nibble phase and then a lower-nibble phase, and builds the 8-bit result in an output register. Upper-phase bits land in data bits 7..4 and lower-phase bits in bits 3..0. Each nibble's value is taken from a digital sample input at the moment that nibble is latched. The analog comparators are not part of the block.

A static mode pin picks between two bus protocols. With mode low, the processor starts a conversion by pulling chip select and read low together. It keeps read low until the data appears. The write/ready pin then serves as an open-drain ready status. With mode high, a write strobe starts the conversion, and its rising edge closes the upper phase. The lower phase runs for a parameterised number of clock cycles. A read pulled low during the lower phase ends that phase at once.

An interrupt output marks the end of each conversion. An acquisition counter flags any start request that arrives too soon after the previous end, and that request is dropped. All three strobes pass through a two-flop synchronizer before their edges are detected. The channel address is captured when a conversion starts.

Top module: `adc_bus_seq`

## Requirements
- R1: With mode=0, a falling edge of the combined condition (cs_n low and rd_n low) starts a conversion. The upper phase lasts HI_CYCLES clocks and the lower phase lasts LO_CYCLES clocks. Counted in rising clock edges from the input change, int_n falls after SYNC_STAGES+1+HI_CYCLES+LO_CYCLES edges, and the result is then driven while cs_n and rd_n stay low.
- R2: With mode=0, rdy_pull_low goes to 1 after cs_n falls and returns to 0 when the conversion ends or cs_n rises. With mode=1 it stays 0.
- R3: int_n goes low in the cycle a conversion ends and returns high after a rising edge of cs_n or rd_n.
- R4: With mode=1, a falling edge of wr_n while cs_n is low starts a conversion. The rising edge of wr_n latches hi_sample into data bits 7..4 and starts the lower phase. int_n falls SYNC_STAGES+1+LO_CYCLES edges after wr_n rises.
- R5: data_oe is 1 only while cs_n and rd_n are both low and no conversion is running. While data_oe is 0, data_out is 0.
- R6: With mode=1, if rd_n falls while cs_n is low during the lower phase, the conversion ends on the next edge. lo_sample is latched into bits 3..0 at that point, and int_n falls SYNC_STAGES+2 edges after wr_n rises when rd_n drops one edge after wr_n.
- R7: addr is captured when a conversion is accepted and is shown on chan_out with the result.
- R8: A start request arriving within ACQ_CYCLES clocks of a conversion end produces a one-cycle acq_viol pulse and is ignored: int_n and the result register stay as they were. A request after the interval is accepted.
- R9: After reset, int_n=1, rdy_pull_low=0, data_oe=0, data_out=0 and acq_viol=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 1 | Protocol select, held static: 0 read-started, 1 write-started |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low (used when mode=1) |
| addr | input | 3 | Channel address |
| hi_sample | input | 4 | Upper-nibble result of the coarse phase |
| lo_sample | input | 4 | Lower-nibble result of the fine phase |
| data_out | output | 8 | Result bus value, zero when not enabled |
| data_oe | output | 1 | Output buffer enable for data_out |
| int_n | output | 1 | End-of-conversion flag, active low |
| rdy_pull_low | output | 1 | Open-drain ready: 1 pulls the pin low |
| chan_out | output | 3 | Channel of the current result |
| acq_viol | output | 1 | Pulse: start request during acquisition interval |

## Verification
Two functions can land in the same cycle: the internal lower-phase countdown and the read-driven cut-off of that phase. The bench provokes the cut-off by dropping rd_n one clock after wr_n rises, well before the countdown would expire. It judges the result by the exact edge on which int_n falls, which is earlier than the timed path, and by the value latched into the lower nibble. A second collision is a start request arriving while the acquisition counter is still running. The bench judges it by the acq_viol pulse and by int_n and the stored result staying unchanged.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_HI     = 2'd1,
    ST_WAITWR = 2'd2,
    ST_LO     = 2'd3
  } seq_state_e;

  // Place one nibble into the result word; upper selects bits 7..4.
  function automatic logic [7:0] put_nibble(input logic [7:0] cur,
                                            input logic [3:0] nib,
                                            input logic       upper);
    logic [7:0] r;
    r = cur;
    if (upper) r[7:4] = nib;
    else       r[3:0] = nib;
    return r;
  endfunction

  // Rising clock edges from an input change to int_n falling on the timed path.
  function automatic int timed_latency(input int sync_stages, input int phase_cycles);
    return sync_stages + 1 + phase_cycles;
  endfunction
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_n,
  output logic lvl,
  output logic fell,
  output logic rose
);
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '1;
    else        sh <= {sh[STAGES-1:0], raw_n};
  end

  assign lvl  = sh[STAGES-1];
  assign fell = sh[STAGES] & ~sh[STAGES-1];
  assign rose = ~sh[STAGES] & sh[STAGES-1];
endmodule

// File: rtl/conv_seq.sv
module conv_seq
  import adc_seq_pkg::*;
#(
  parameter int HI_CYCLES  = 3,
  parameter int LO_CYCLES  = 4,
  parameter int ACQ_CYCLES = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode,
  input  logic       cs_lvl,
  input  logic       cs_fell,
  input  logic       cs_rose,
  input  logic       rd_lvl,
  input  logic       rd_fell,
  input  logic       rd_rose,
  input  logic       wr_lvl,
  input  logic       wr_fell,
  input  logic       wr_rose,
  input  logic [2:0] addr,
  input  logic [3:0] hi_sample,
  input  logic [3:0] lo_sample,
  output logic [7:0] data_q,
  output logic [2:0] chan_q,
  output logic       int_n,
  output logic       rdy_low,
  output logic       acq_viol,
  output logic       busy,
  output logic       conv_end,
  output logic       hi_latch,
  output logic       override
);
  localparam int MAXPH = (HI_CYCLES > LO_CYCLES) ? HI_CYCLES : LO_CYCLES;
  localparam int CW    = $clog2(MAXPH + 1);
  localparam int AW    = $clog2(ACQ_CYCLES + 1);

  seq_state_e      state;
  logic [CW-1:0]   cnt;
  logic [AW-1:0]   acq_cnt;
  logic            start0, start1, start_req, accept, acq_busy, cnt_zero;

  assign start0    = ~mode & ~cs_lvl & ~rd_lvl & (cs_fell | rd_fell);
  assign start1    = mode & wr_fell & ~cs_lvl;
  assign start_req = (state == ST_IDLE) & (start0 | start1);
  assign acq_busy  = (acq_cnt != '0);
  assign accept    = start_req & ~acq_busy;
  assign cnt_zero  = (cnt == '0);
  assign busy      = (state != ST_IDLE);

  assign hi_latch  = ((state == ST_HI) & cnt_zero) | ((state == ST_WAITWR) & wr_rose);
  assign override  = (state == ST_LO) & mode & rd_fell & ~cs_lvl & wr_lvl;
  assign conv_end  = (state == ST_LO) & (cnt_zero | override);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      data_q <= '0;
      chan_q <= '0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          chan_q <= addr;
          if (mode) state <= ST_WAITWR;
          else begin
            state <= ST_HI;
            cnt   <= CW'(HI_CYCLES - 1);
          end
        end
        ST_HI, ST_WAITWR: begin
          if (hi_latch) begin
            data_q <= put_nibble(data_q, hi_sample, 1'b1);
            cnt    <= CW'(LO_CYCLES - 1);
            state  <= ST_LO;
          end else if (state == ST_HI) begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_LO: begin
          if (conv_end) begin
            data_q <= put_nibble(data_q, lo_sample, 1'b0);
            state  <= ST_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_n    <= 1'b1;
      rdy_low  <= 1'b0;
      acq_cnt  <= '0;
      acq_viol <= 1'b0;
    end else begin
      acq_viol <= start_req & acq_busy;

      if (conv_end)                int_n <= 1'b0;
      else if (accept)             int_n <= 1'b1;
      else if (cs_rose | rd_rose)  int_n <= 1'b1;

      if (mode)                    rdy_low <= 1'b0;
      else if (conv_end | cs_rose) rdy_low <= 1'b0;
      else if (cs_fell)            rdy_low <= 1'b1;

      if (conv_end)      acq_cnt <= AW'(ACQ_CYCLES);
      else if (acq_busy) acq_cnt <= acq_cnt - 1'b1;
    end
  end
endmodule

// File: rtl/adc_bus_seq.sv
module adc_bus_seq #(
  parameter int SYNC_STAGES = 2,
  parameter int HI_CYCLES   = 3,
  parameter int LO_CYCLES   = 4,
  parameter int ACQ_CYCLES  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode,
  input  logic       cs_n,
  input  logic       rd_n,
  input  logic       wr_n,
  input  logic [2:0] addr,
  input  logic [3:0] hi_sample,
  input  logic [3:0] lo_sample,
  output logic [7:0] data_out,
  output logic       data_oe,
  output logic       int_n,
  output logic       rdy_pull_low,
  output logic [2:0] chan_out,
  output logic       acq_viol
);
  localparam int NSTB = 3;  // 0: chip select, 1: read, 2: write

  logic [NSTB-1:0] raw_v, lvl_v, fell_v, rose_v;
  logic [7:0]      data_q_w;
  logic            busy_w, conv_end_w, hi_latch_w, override_w;

  assign raw_v = {wr_n, rd_n, cs_n};

  for (genvar g = 0; g < NSTB; g++) begin : g_sync
    strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .raw_n (raw_v[g]),
      .lvl   (lvl_v[g]),
      .fell  (fell_v[g]),
      .rose  (rose_v[g])
    );
  end

  conv_seq #(
    .HI_CYCLES  (HI_CYCLES),
    .LO_CYCLES  (LO_CYCLES),
    .ACQ_CYCLES (ACQ_CYCLES)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .cs_lvl    (lvl_v[0]),
    .cs_fell   (fell_v[0]),
    .cs_rose   (rose_v[0]),
    .rd_lvl    (lvl_v[1]),
    .rd_fell   (fell_v[1]),
    .rd_rose   (rose_v[1]),
    .wr_lvl    (lvl_v[2]),
    .wr_fell   (fell_v[2]),
    .wr_rose   (rose_v[2]),
    .addr      (addr),
    .hi_sample (hi_sample),
    .lo_sample (lo_sample),
    .data_q    (data_q_w),
    .chan_q    (chan_out),
    .int_n     (int_n),
    .rdy_low   (rdy_pull_low),
    .acq_viol  (acq_viol),
    .busy      (busy_w),
    .conv_end  (conv_end_w),
    .hi_latch  (hi_latch_w),
    .override  (override_w)
  );

  assign data_oe  = ~lvl_v[0] & ~lvl_v[1] & ~busy_w;
  assign data_out = data_oe ? data_q_w : 8'h00;
endmodule

// File: rtl/adc_bus_seq_chk.sv
module adc_bus_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mode,
  input logic [3:0] hi_sample,
  input logic [2:0] chan_out,
  input logic       int_n,
  input logic       rdy_pull_low,
  input logic       acq_viol,
  input logic [7:0] data_q_w,
  input logic       busy_w,
  input logic       conv_end_w,
  input logic       hi_latch_w,
  input logic       override_w
);
  a_r3_int_falls_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(int_n) |-> $past(conv_end_w));

  a_r2_ready_idle_mode1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode && $past(mode)) |-> !rdy_pull_low);

  a_r4_upper_latched: assert property (@(posedge clk) disable iff (!rst_n)
    hi_latch_w |=> (data_q_w[7:4] == $past(hi_sample)));

  a_r6_cut_ends_now: assert property (@(posedge clk) disable iff (!rst_n)
    override_w |=> (!busy_w && !int_n));

  a_r7_chan_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_w && $past(busy_w)) |-> $stable(chan_out));

  a_r8_early_start_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    acq_viol |-> !busy_w);
endmodule

bind adc_bus_seq adc_bus_seq_chk chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .mode         (mode),
  .hi_sample    (hi_sample),
  .chan_out     (chan_out),
  .int_n        (int_n),
  .rdy_pull_low (rdy_pull_low),
  .acq_viol     (acq_viol),
  .data_q_w     (data_q_w),
  .busy_w       (busy_w),
  .conv_end_w   (conv_end_w),
  .hi_latch_w   (hi_latch_w),
  .override_w   (override_w)
);

// File: tb/adc_bus_seq_tb_top.sv
`timescale 1ns/1ps
module adc_bus_seq_tb_top;
  localparam int SYNC = 2;
  localparam int HI   = 3;
  localparam int LO   = 4;
  localparam int ACQ  = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode = 1'b0, cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [2:0] addr = '0;
  logic [3:0] hi_sample = '0, lo_sample = '0;
  logic [7:0] data_out;
  logic       data_oe, int_n, rdy_pull_low, acq_viol;
  logic [2:0] chan_out;

  int checks = 0, errors = 0, viol_cnt = 0;

  always #2 clk = ~clk;

  adc_bus_seq #(.SYNC_STAGES(SYNC), .HI_CYCLES(HI), .LO_CYCLES(LO), .ACQ_CYCLES(ACQ)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode(mode), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .hi_sample(hi_sample), .lo_sample(lo_sample), .data_out(data_out),
    .data_oe(data_oe), .int_n(int_n), .rdy_pull_low(rdy_pull_low), .chan_out(chan_out),
    .acq_viol(acq_viol));

  always @(negedge clk) if (rst_n && acq_viol) viol_cnt++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Edges from now until int_n is seen low at a falling edge.
  task automatic wait_int(output int n);
    n = 0;
    for (int i = 0; i < 60; i++) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (!int_n) break;
    end
  endtask

  task automatic t_reset();
    chk("R9 int_n", int_n, 1);
    chk("R9 rdy", rdy_pull_low, 0);
    chk("R9 oe", data_oe, 0);
    chk("R9 data", data_out, 0);
    chk("R9 viol", acq_viol, 0);
  endtask

  task automatic t_mode0();
    int n;
    mode = 0; addr = 3'd5; hi_sample = 4'hA; lo_sample = 4'h3;
    cs_n = 0; rd_n = 0;
    n = 0;
    for (int i = 0; i < 60; i++) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (n == 4) begin
        chk("R2 ready pulled during conversion", rdy_pull_low, 1);
        chk("R5 no drive while converting", data_oe, 0);
      end
      if (!int_n) break;
    end
    chk("R1 mode0 latency", n, SYNC + 1 + HI + LO);
    chk("R2 ready released at end", rdy_pull_low, 0);
    chk("R1 result driven", data_oe, 1);
    chk("R1 result value", data_out, 8'hA3);
    chk("R7 channel mode0", chan_out, 5);
    rd_n = 1; idle(4);
    chk("R3 int high after read rises", int_n, 1);
    chk("R5 no drive after read rises", data_oe, 0);
    cs_n = 1; idle(ACQ + 4);
  endtask

  task automatic t_mode1_timed();
    int n;
    mode = 1; addr = 3'd2; hi_sample = 4'h6; lo_sample = 4'h9;
    idle(2);
    cs_n = 0; wr_n = 0; idle(4);
    wr_n = 1;
    wait_int(n);
    chk("R4 mode1 timed latency", n, SYNC + 1 + LO);
    chk("R2 ready unused in mode1", rdy_pull_low, 0);
    chk("R5 no drive before read", data_oe, 0);
    rd_n = 0; idle(4);
    chk("R5 drive on read", data_oe, 1);
    chk("R4 mode1 result", data_out, 8'h69);
    chk("R7 channel mode1", chan_out, 2);
    chk("R3 int still low during read", int_n, 0);
    rd_n = 1; idle(4);
    chk("R3 int high after read", int_n, 1);
    cs_n = 1; idle(ACQ + 4);
  endtask

  task automatic t_override();
    int n;
    mode = 1; addr = 3'd7; hi_sample = 4'hC; lo_sample = 4'h5;
    cs_n = 0; wr_n = 0; idle(4);
    wr_n = 1;
    n = 0;
    for (int i = 0; i < 60; i++) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (n == 1) rd_n = 0;
      if (!int_n) break;
    end
    chk("R6 cut-short latency", n, SYNC + 2);
    chk("R6 drive after cut", data_oe, 1);
    chk("R6 result after cut", data_out, 8'hC5);
    chk("R7 channel after cut", chan_out, 7);
    rd_n = 1; cs_n = 1; idle(4);
    chk("R3 int high after cs/rd rise", int_n, 1);
    idle(ACQ + 4);
  endtask

  task automatic t_acq();
    int n, v0;
    mode = 1; addr = 3'd1; hi_sample = 4'h1; lo_sample = 4'h2;
    cs_n = 0; wr_n = 0; idle(4);
    wr_n = 1;
    wait_int(n);
    chk("R4 latency before early start", n, SYNC + 1 + LO);
    v0 = viol_cnt;
    hi_sample = 4'hF; lo_sample = 4'hE; addr = 3'd6;
    wr_n = 0; idle(4);
    chk("R8 early start flagged", viol_cnt - v0, 1);
    chk("R8 int untouched by early start", int_n, 0);
    wr_n = 1; idle(ACQ + 4);
    chk("R8 int still low", int_n, 0);
    rd_n = 0; idle(4);
    chk("R8 result kept", data_out, 8'h12);
    chk("R8 channel kept", chan_out, 1);
    rd_n = 1; idle(4);
    chk("R3 int high again", int_n, 1);
    wr_n = 0; idle(4);
    wr_n = 1;
    wait_int(n);
    chk("R8 start accepted after interval", n, SYNC + 1 + LO);
    chk("R8 no extra flag", viol_cnt - v0, 1);
    rd_n = 0; idle(4);
    chk("R8 new result", data_out, 8'hFE);
    rd_n = 1; cs_n = 1; idle(ACQ + 4);
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle(3);
    t_reset();
    rst_n = 1;
    idle(3);
    t_mode0();
    t_mode1_timed();
    t_override();
    t_acq();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule